// File: doc/BRIEF.md
# Floating-Point Control Register Transfer Sequencer

This block carries out the instruction that moves the floating-point unit's three 32-bit system registers (rounding/control, status, and last-instruction address) to or from a single operand. The operand is a data register or memory. A start pulse presents the instruction extension word, the 6-bit effective-address field of the opcode, and an operand address that an upstream unit has already computed. The block reads the transfer direction and a three-bit selection mask from the extension word. It then moves each selected register in turn, one 32-bit transfer for each. The order is fixed: control first, then status, then the instruction address register.

Memory operands use a request/acknowledge port that carries a single access at a time. Data-register operands use a small register-file port. In the displaced and indexed memory modes the address is taken once and advances by one word after every transfer, so the selected registers land in consecutive words. In every other memory mode the same address is used for every transfer. A bus error ends the instruction early and sets a flag. An instruction that moves at least one register is held to a fixed occupancy of ten clock edges before `done`, the same cost the instruction always carries. The three registers are visible as outputs.

Top module: `fpctl_xfer_seq`

## Requirements
- R1: While `rst` is high, and after it falls, `ctl_q`, `sts_q`, `iar_q`, `bus_req`, `rf_wr`, `busy`, `done` and `err` are all zero.
- R2: Bit 13 of `ext_word` sets the direction. With 1 the selected registers are copied out (`bus_we`=1 with the register value on `bus_wdata`, or a register-file write). With 0 they are loaded from the operand. All bits of `ext_word` other than 13..10 have no effect.
- R3: Bits 12, 11 and 10 of `ext_word` select control, status and instruction-address respectively. Selected registers transfer in the order control, status, instruction-address. A register that is not selected keeps its value.
- R4: A memory access holds `bus_req`, `bus_addr` and `bus_we` steady until `bus_ack` or `bus_err`. Only one access is outstanding at a time, and a bus access never overlaps a register-file write.
- R5: In modes 5 and 6 (`ea_field[5:3]`) the first access uses the operand address, and each later access uses an address 4 higher than the one before.
- R6: In memory modes other than 0, 5 and 6, every access uses the operand address unchanged.
- R7: In mode 0 the register-file port is used with `rf_sel` = `ea_field[2:0]`. A load copies `rf_rdata` into each selected register. A store issues one `rf_wr` pulse per selected register, in the order of R3.
- R8: In a memory mode with `ea_addr_vld` low, the base address is 0xFFFFFFFF, and it steps from there as in R5 or R6.
- R9: A `bus_err` response ends the instruction. `done` and `err` rise at the same edge, no further access is made, and registers that have not yet transferred keep their values. `err` stays high until the next start.
- R10: With an empty mask the block makes no access and raises `done` at the edge that samples `start`. `err` is then low.
- R11: With a non-empty mask and no error, `done` rises exactly 10 edges after the start edge whenever the transfers finish sooner. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (sampled when idle) |
| ext_word | input | 16 | Instruction extension word |
| ea_field | input | 6 | Opcode effective-address field: mode in 5:3, register in 2:0 |
| ea_addr | input | 32 | Precomputed operand address |
| ea_addr_vld | input | 1 | Operand address was computed |
| bus_req | output | 1 | Memory access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 32 | Access address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Access completed |
| bus_err | input | 1 | Access failed |
| rf_sel | output | 3 | Data-register number |
| rf_wr | output | 1 | Data-register write strobe |
| rf_wdata | output | 32 | Data-register write value |
| rf_rdata | input | 32 | Data-register read value for `rf_sel` |
| ctl_q | output | 32 | Control register |
| sts_q | output | 32 | Status register |
| iar_q | output | 32 | Instruction address register |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Instruction finished (one cycle) |
| err | output | 1 | Last instruction ended on a bus error |

## Verification
The pending mask and the address stepper are the internal state most likely to be corrupted. A fault in the pending mask shows on the bus within one access: a register is skipped, repeated or moved out of order, and the access count or the data at a given address is wrong. A fault in the stepper shows as a wrong address on the second access of a multi-register move. A wrong count or a slip in the occupancy counter moves `done` off edge 10, and that is visible at the end of every instruction. Errors are injected at the first and at a middle access, so an abort that goes too far or stops too early shows in the register outputs as soon as `done` is seen.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int REG_CNT = 3;   // index 0 control, 1 status, 2 instruction address

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_PAD
  } fpx_state_e;

  typedef enum logic [1:0] {
    OPND_REG,
    OPND_MEM_STEP,
    OPND_MEM_FIXED
  } opnd_e;
endpackage

// File: rtl/fpx_decode.sv
module fpx_decode
  import fpx_pkg::*;
#(
  parameter int EXT_W   = 16,
  parameter int EA_W    = 6,
  parameter int DIR_BIT = 13,
  parameter int MASK_LO = 10,
  parameter int REG_N   = 3
) (
  input  logic [EXT_W-1:0] ext_word,
  input  logic [EA_W-1:0]  ea_field,
  output logic             dir,
  output logic [REG_N-1:0] sel,
  output opnd_e            kind,
  output logic [2:0]       rnum
);
  localparam int MODE_LO = 3;

  logic [2:0] mode;
  logic       unused_ext;

  assign dir        = ext_word[DIR_BIT];
  assign mode       = ea_field[MODE_LO +: 3];
  assign rnum       = ea_field[2:0];
  assign unused_ext = ^ext_word;

  // highest mask bit maps to index 0, which transfers first
  for (genvar i = 0; i < REG_N; i++) begin : g_sel
    assign sel[i] = ext_word[MASK_LO + REG_N - 1 - i];
  end

  always_comb begin
    if (mode == 3'd0)                       kind = OPND_REG;
    else if (mode == 3'd5 || mode == 3'd6)  kind = OPND_MEM_STEP;
    else                                    kind = OPND_MEM_FIXED;
  end
endmodule

// File: rtl/fpx_pick.sv
module fpx_pick #(
  parameter int REG_N = 3
) (
  input  logic [REG_N-1:0] pending,
  output logic [REG_N-1:0] first_oh,
  output logic             any
);
  // lowest set bit wins: fixed order control, status, address
  assign first_oh = pending & (~pending + REG_N'(1));
  assign any      = |pending;
endmodule

// File: rtl/fpx_addr_step.sv
module fpx_addr_step #(
  parameter int ADDR_W    = 32,
  parameter int ADDR_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= base;
    else if (step) addr <= addr + ADDR_W'(ADDR_STEP);
  end
endmodule

// File: rtl/fpx_ctlregs.sv
module fpx_ctlregs #(
  parameter int DATA_W = 32,
  parameter int REG_N  = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [REG_N-1:0]              we,
  input  logic [DATA_W-1:0]             wdata,
  output logic [REG_N-1:0][DATA_W-1:0]  q
);
  for (genvar i = 0; i < REG_N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)        q[i] <= '0;
      else if (we[i]) q[i] <= wdata;
    end
  end
endmodule

// File: rtl/fpctl_xfer_seq.sv
module fpctl_xfer_seq
  import fpx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int EXT_W     = 16,
  parameter int EA_W      = 6,
  parameter int DIR_BIT   = 13,
  parameter int MASK_LO   = 10,
  parameter int ADDR_STEP = 4,
  parameter int MIN_CYC   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [EXT_W-1:0]  ext_word,
  input  logic [EA_W-1:0]   ea_field,
  input  logic [ADDR_W-1:0] ea_addr,
  input  logic              ea_addr_vld,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  output logic [2:0]        rf_sel,
  output logic              rf_wr,
  output logic [DATA_W-1:0] rf_wdata,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [DATA_W-1:0] ctl_q,
  output logic [DATA_W-1:0] sts_q,
  output logic [DATA_W-1:0] iar_q,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int REG_N = REG_CNT;
  localparam int CNT_W = $clog2(MIN_CYC + 1);

  fpx_state_e state;
  opnd_e      kind_q;
  logic       dir_q;
  logic [REG_N-1:0] pending;
  logic [REG_N-1:0] cur_oh;
  logic [CNT_W-1:0] occ_cnt;

  logic             dec_dir;
  logic [REG_N-1:0] dec_sel;
  opnd_e            dec_kind;
  logic [2:0]       dec_rnum;

  logic [REG_N-1:0] pk_oh;
  logic             pk_any;

  logic                          ag_load, ag_step;
  logic [ADDR_W-1:0]             ag_base, ag_addr;
  logic [REG_N-1:0]              rb_we;
  logic [DATA_W-1:0]             rb_wdata;
  logic [REG_N-1:0][DATA_W-1:0]  rb_q;

  function automatic logic [DATA_W-1:0] sel_word(
    input logic [REG_N-1:0]             oh,
    input logic [REG_N-1:0][DATA_W-1:0] w
  );
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < REG_N; i++) begin
      if (oh[i]) r = r | w[i];
    end
    return r;
  endfunction

  fpx_decode #(
    .EXT_W(EXT_W), .EA_W(EA_W), .DIR_BIT(DIR_BIT), .MASK_LO(MASK_LO), .REG_N(REG_N)
  ) u_dec (
    .ext_word(ext_word), .ea_field(ea_field),
    .dir(dec_dir), .sel(dec_sel), .kind(dec_kind), .rnum(dec_rnum)
  );

  fpx_pick #(.REG_N(REG_N)) u_pick (
    .pending(pending), .first_oh(pk_oh), .any(pk_any)
  );

  assign ag_load = (state == ST_IDLE) && start;
  assign ag_base = ea_addr_vld ? ea_addr : {ADDR_W{1'b1}};
  assign ag_step = (state == ST_WAIT) && bus_ack && !bus_err && (kind_q == OPND_MEM_STEP);

  fpx_addr_step #(.ADDR_W(ADDR_W), .ADDR_STEP(ADDR_STEP)) u_addr (
    .clk(clk), .rst(rst), .load(ag_load), .base(ag_base), .step(ag_step), .addr(ag_addr)
  );

  always_comb begin
    rb_we    = '0;
    rb_wdata = bus_rdata;
    if (state == ST_ISSUE && kind_q == OPND_REG && !dir_q && pk_any) begin
      rb_we    = pk_oh;
      rb_wdata = rf_rdata;
    end else if (state == ST_WAIT && bus_ack && !bus_err && !dir_q) begin
      rb_we    = cur_oh;
    end
  end

  fpx_ctlregs #(.DATA_W(DATA_W), .REG_N(REG_N)) u_regs (
    .clk(clk), .rst(rst), .we(rb_we), .wdata(rb_wdata), .q(rb_q)
  );

  assign ctl_q = rb_q[0];
  assign sts_q = rb_q[1];
  assign iar_q = rb_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      kind_q    <= OPND_REG;
      dir_q     <= 1'b0;
      pending   <= '0;
      cur_oh    <= '0;
      occ_cnt   <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rf_sel    <= '0;
      rf_wr     <= 1'b0;
      rf_wdata  <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done  <= 1'b0;
      rf_wr <= 1'b0;
      if (state != ST_IDLE && occ_cnt < CNT_W'(MIN_CYC)) occ_cnt <= occ_cnt + CNT_W'(1);
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            dir_q   <= dec_dir;
            kind_q  <= dec_kind;
            pending <= dec_sel;
            rf_sel  <= dec_rnum;
            err     <= 1'b0;
            occ_cnt <= CNT_W'(1);
            if (dec_sel == '0) begin
              done <= 1'b1;
            end else begin
              busy  <= 1'b1;
              state <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (!pk_any) begin
            state <= ST_PAD;
          end else begin
            pending <= pending & ~pk_oh;
            cur_oh  <= pk_oh;
            if (kind_q == OPND_REG) begin
              if (dir_q) begin
                rf_wr    <= 1'b1;
                rf_wdata <= sel_word(pk_oh, rb_q);
              end
            end else begin
              bus_req   <= 1'b1;
              bus_we    <= dir_q;
              bus_addr  <= ag_addr;
              bus_wdata <= sel_word(pk_oh, rb_q);
              state     <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (bus_err) begin
            bus_req <= 1'b0;
            bus_we  <= 1'b0;
            err     <= 1'b1;
            done    <= 1'b1;
            busy    <= 1'b0;
            pending <= '0;
            state   <= ST_IDLE;
          end else if (bus_ack) begin
            bus_req <= 1'b0;
            bus_we  <= 1'b0;
            state   <= ST_ISSUE;
          end
        end
        ST_PAD: begin
          if (occ_cnt >= CNT_W'(MIN_CYC)) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpx_xfer_chk.sv
module fpx_xfer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              bus_err,
  input logic              rf_wr,
  input logic              busy,
  input logic              done,
  input logic              err
);
  // R4: request, address and direction held until a response
  a_r4_hold_req: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack && !bus_err |=> bus_req && $stable(bus_addr) && $stable(bus_we));

  // R4: bus and register-file paths never active together
  a_r4_one_path: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && rf_wr));

  // R9: bus error ends the instruction at once
  a_r9_err_ends: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_err |=> done && err && !bus_req && !busy);

  // R11: done is a one-cycle pulse unless a new instruction starts
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> !done);

  // R1: nothing reaches the operand ports while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_req && !rf_wr);
endmodule

bind fpctl_xfer_seq fpx_xfer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_err(bus_err), .rf_wr(rf_wr),
  .busy(busy), .done(done), .err(err)
);

// File: tb/test_fpctl_xfer_seq.sv
`timescale 1ns/1ps
module test_fpctl_xfer_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [15:0] ext_word = '0;
  logic [5:0]  ea_field = '0;
  logic [31:0] ea_addr = '0;
  logic        ea_addr_vld = 1'b0;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;
  logic        bus_err = 1'b0;
  logic [2:0]  rf_sel;
  logic        rf_wr;
  logic [31:0] rf_wdata, rf_rdata;
  logic [31:0] ctl_q, sts_q, iar_q;
  logic        busy, done, err;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] rf_f(input logic [2:0] s);
    return 32'h1000_0000 + ({29'b0, s} * 32'h111);
  endfunction
  function automatic logic [31:0] mem_f(input logic [31:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction

  assign rf_rdata = rf_f(rf_sel);

  fpctl_xfer_seq i_fpctl_xfer_seq (
    .clk(clk), .rst(rst), .start(start), .ext_word(ext_word), .ea_field(ea_field),
    .ea_addr(ea_addr), .ea_addr_vld(ea_addr_vld), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .bus_err(bus_err), .rf_sel(rf_sel), .rf_wr(rf_wr), .rf_wdata(rf_wdata),
    .rf_rdata(rf_rdata), .ctl_q(ctl_q), .sts_q(sts_q), .iar_q(iar_q),
    .busy(busy), .done(done), .err(err)
  );

  int n_chk = 0;
  int n_fail = 0;
  int ack_delay = 0;
  int wait_cnt = 0;
  int err_at = 7;
  int log_n = 0;
  int rf_n = 0;
  logic [31:0] log_addr [8];
  logic        log_we   [8];
  logic [31:0] log_wd   [8];
  logic [31:0] rf_log   [8];
  logic [31:0] em [3];

  // memory responder: one access at a time, optional wait, optional error
  always @(negedge clk) begin
    if (bus_req && !bus_ack && !bus_err) begin
      if (wait_cnt < ack_delay) begin
        wait_cnt++;
      end else begin
        wait_cnt = 0;
        if (log_n < 8) begin
          log_addr[log_n] = bus_addr;
          log_we[log_n]   = bus_we;
          log_wd[log_n]   = bus_wdata;
        end
        bus_rdata = mem_f(bus_addr);
        if (log_n == err_at) bus_err = 1'b1;
        else                 bus_ack = 1'b1;
        log_n++;
      end
    end else begin
      bus_ack  = 1'b0;
      bus_err  = 1'b0;
      wait_cnt = 0;
    end
  end

  always @(negedge clk) begin
    if (rf_wr) begin
      if (rf_n < 8) rf_log[rf_n] = rf_wdata;
      rf_n++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ext, ea_field, address, address valid, index of access that errors (7 = none)
  localparam logic [57:0] VEC [0:10] = '{
    {16'h1C00, 6'o52, 32'h0000_0100, 1'b1, 3'd7},  // load all, displaced
    {16'h3C37, 6'o63, 32'h0000_0200, 1'b1, 3'd7},  // store all, indexed, junk low bits
    {16'h0800, 6'o21, 32'h0000_0300, 1'b1, 3'd7},  // load status, fixed
    {16'h2C00, 6'o33, 32'h0000_0400, 1'b1, 3'd7},  // store status+addr, fixed
    {16'h1400, 6'o03, 32'h0000_0000, 1'b1, 3'd7},  // load ctl+addr from D3
    {16'h3800, 6'o05, 32'h0000_0000, 1'b1, 3'd7},  // store ctl+status to D5
    {16'h1C00, 6'o54, 32'h0000_0500, 1'b0, 3'd0},  // unassigned address, error first
    {16'h1C00, 6'o52, 32'h0000_0600, 1'b1, 3'd1},  // error on second access
    {16'hC3FF, 6'o52, 32'h0000_0700, 1'b1, 3'd7},  // empty mask
    {16'h2000, 6'o00, 32'h0000_0000, 1'b1, 3'd7},  // empty mask, store, register
    {16'h1C00, 6'o65, 32'h0000_0000, 1'b0, 3'd7}   // unassigned address, stepping wraps
  };

  task automatic run_vec(input logic [57:0] v);
    logic [15:0] ext;
    logic [5:0]  ea;
    logic [31:0] addr, base;
    logic        vld, dir, step_m, exp_err;
    logic [2:0]  selv, mode;
    int errk, k, lat, ex_n, ex_rf_n;
    logic [31:0] ex_addr [8];
    logic        ex_we [8];
    logic [31:0] ex_wd [8];
    logic [31:0] ex_rf [8];
    string atag;
    ext  = v[57:42]; ea = v[41:36]; addr = v[35:4]; vld = v[3]; errk = int'(v[2:0]);
    dir  = ext[13];
    selv = {ext[12], ext[11], ext[10]};
    mode = ea[5:3];
    base = vld ? addr : 32'hFFFF_FFFF;
    step_m = (mode == 3'd5) || (mode == 3'd6);
    atag = !vld ? "R8 address" : (step_m ? "R5 address" : "R6 address");
    ex_n = 0; ex_rf_n = 0; k = 0; exp_err = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (selv[2-i]) begin
        if (mode == 3'd0) begin
          if (dir) begin ex_rf[ex_rf_n] = em[i]; ex_rf_n++; end
          else em[i] = rf_f(ea[2:0]);
        end else if (!exp_err) begin
          ex_addr[ex_n] = step_m ? base + 32'(4 * k) : base;
          ex_we[ex_n]   = dir;
          ex_wd[ex_n]   = em[i];
          if (k == errk) exp_err = 1'b1;
          else if (!dir) em[i] = mem_f(ex_addr[ex_n]);
          ex_n++;
          k++;
        end
      end
    end
    @(negedge clk);
    log_n = 0; rf_n = 0; err_at = errk;
    ext_word = ext; ea_field = ea; ea_addr = addr; ea_addr_vld = vld; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk("R11 done seen", {31'b0, done}, 32'd1);
    if (selv == 3'b000) chk("R10 no access", log_n, 32'd0);
    else                chk("R3 access count", log_n, ex_n);
    for (int i = 0; i < ex_n && i < log_n; i++) begin
      chk(atag, log_addr[i], ex_addr[i]);
      chk("R2 direction", {31'b0, log_we[i]}, {31'b0, ex_we[i]});
      if (ex_we[i]) chk("R2 store data", log_wd[i], ex_wd[i]);
    end
    chk("R7 rf write count", rf_n, ex_rf_n);
    for (int i = 0; i < ex_rf_n && i < rf_n; i++) chk("R7 rf write data", rf_log[i], ex_rf[i]);
    if (mode == 3'd0 && selv != 3'b000) chk("R7 rf_sel", {29'b0, rf_sel}, {29'b0, ea[2:0]});
    chk("R3 ctl_q", ctl_q, em[0]);
    chk("R3 sts_q", sts_q, em[1]);
    chk("R3 iar_q", iar_q, em[2]);
    chk("R9 err flag", {31'b0, err}, {31'b0, exp_err});
    if (selv == 3'b000)  chk("R10 latency", lat, 32'd0);
    else if (!exp_err)   chk("R11 latency", lat, 32'd10);
  endtask

  initial begin
    #500us;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) em[i] = '0;
    repeat (4) @(negedge clk);
    chk("R1 reset ctl_q", ctl_q, 32'd0);
    chk("R1 reset sts_q", sts_q, 32'd0);
    chk("R1 reset iar_q", iar_q, 32'd0);
    chk("R1 reset outputs", {28'b0, bus_req, rf_wr, busy, done | err}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {29'b0, bus_req, busy, done}, 32'd0);

    for (int v = 0; v < 11; v++) run_vec(VEC[v]);

    // R4: delayed acknowledge keeps the request and address held
    ack_delay = 3;
    @(negedge clk);
    log_n = 0; err_at = 7;
    ext_word = 16'h1000; ea_field = 6'o52; ea_addr = 32'h0000_0700; ea_addr_vld = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 request held", {31'b0, bus_req}, 32'd1);
    chk("R4 address held", bus_addr, 32'h0000_0700);
    chk("R4 no early completion", log_n, 32'd0);
    for (int n = 0; n < 40 && !done; n++) @(negedge clk);
    em[0] = mem_f(32'h0000_0700);
    chk("R4 load after wait", ctl_q, em[0]);
    chk("R4 single access", log_n, 32'd1);

    // R1: reset in the middle of a wait
    @(negedge clk);
    ext_word = 16'h1C00; ea_field = 6'o52; ea_addr = 32'h0000_0800; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 mid reset regs", ctl_q | sts_q | iar_q, 32'd0);
    chk("R1 mid reset outputs", {29'b0, bus_req, busy, done}, 32'd0);
    rst = 1'b0;
    ack_delay = 0;
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule